// File: doc/BRIEF.md
# Duty-Cycled Receive Wake Sequencer

This block sets the rhythm of a low-power receiver. It alternates between a long sleep phase and a short listen window. While the duty-cycle mode is on, the block steps through three countdowns in a fixed order:

1. A sleep countdown, during which everything but the sleep timer is treated as powered down.
2. A host-recovery countdown, which gives the host processor time to wake up.
3. A settle countdown, which lets the radio stabilise before data arrive.

The wake line is active low and open-drain in style. It is pulled low when the sleep phase ends and stays low through host recovery and settling. When settling ends, the line is released, a one-clock receive-enable pulse is issued, and a new sleep phase begins.

The host writes the counts and the control bits through an address, data and write-strobe port. All timing is counted in base ticks. A parameterised divider derives the base tick from the system clock (TICK_CYCLES clocks per tick, standing for 120 µs). The sleep phase counts slower ticks: the base tick is divided by a ratio chosen by a 2-bit prescale select.

Top module: `wake_seq_top`

## Requirements
- R1: After reset, wake_n is 1, pwr_down is 0 and rx_en is 0. All configuration registers are zero, so enabling the mode without any other write gives three phases of one tick each.
- R2: A write with wr_en high stores wr_data at the next clock edge, at one of these addresses:
  - 0x1: bit 0 is the mode enable and bits 2:1 are the prescale select.
  - 0x4 / 0x5: upper / lower byte of the 16-bit sleep count.
  - 0x6: the 8-bit host-recovery count.
  - 0x7 / 0x8: upper / lower byte of the 16-bit settle count.

  Writes to any other address change nothing.
- R3: One clock after the mode bit is seen set while idle, the sleep phase starts. pwr_down is then high for (N+1)·P·TICK_CYCLES clocks, where N is the sleep count and P is the prescale ratio.
- R4: Prescale select 0, 1, 2 and 3 give ratios P of 1, 4, 16 and 64 base ticks per sleep tick.
- R5: When the sleep phase ends, pwr_down falls and wake_n goes low. The host-recovery phase then lasts (M+1)·TICK_CYCLES clocks, where M is the host-recovery count.
- R6: The settle phase follows and lasts (K+1)·TICK_CYCLES clocks, where K is the settle count. wake_n stays low and pwr_down stays low during this phase.
- R7: When the settle phase ends, wake_n is released, rx_en is high for exactly one clock, and a new sleep phase starts in the same cycle.
- R8: When the mode bit is cleared, the block is idle from the next clock. It holds wake_n at 1, pwr_down at 0 and rx_en at 0, whatever phase it was in.
- R9: A count of zero makes its phase last exactly one tick of that phase's tick base.
- R10: pwr_down is never high while wake_n is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 8 | Register write data |
| wake_n | output | 1 | Host wake line, low means pulled down |
| pwr_down | output | 1 | High during the sleep phase |
| rx_en | output | 1 | One-clock pulse at the end of settling |

## Verification
The assertions check on every cycle that:
- pwr_down and a low wake line never occur together;
- rx_en never lasts more than one clock, and only appears as a new sleep phase begins;
- a cleared mode bit always lands the sequencer in idle;
- the wake line only falls out of the sleep phase;
- slow ticks coincide with base ticks;
- a host-recovery write is stored.

Only the bench scenarios can show the exact phase lengths, because those come from the counts, the byte split and the four prescale ratios. The bench scenarios also show that stray addresses leave the timing untouched, and that the sequence loops back into sleep.

// File: rtl/wake_seq_pkg.sv
package wake_seq_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SLEEP  = 2'd1,
        PH_HOST   = 2'd2,
        PH_SETTLE = 2'd3
    } phase_e;

    localparam logic [3:0] ADR_CTRL     = 4'h1;
    localparam logic [3:0] ADR_SLEEP_HI = 4'h4;
    localparam logic [3:0] ADR_SLEEP_LO = 4'h5;
    localparam logic [3:0] ADR_HOST     = 4'h6;
    localparam logic [3:0] ADR_SETTLE_HI = 4'h7;
    localparam logic [3:0] ADR_SETTLE_LO = 4'h8;

    typedef struct packed {
        logic        en;
        logic [1:0]  psel;
        logic [15:0] sleep_cnt;
        logic [7:0]  host_cnt;
        logic [15:0] settle_cnt;
    } cfg_t;

endpackage

// File: rtl/wake_seq_regs.sv
module wake_seq_regs
    import wake_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [3:0] wr_addr,
    input  logic [7:0] wr_data,
    output cfg_t       cfg_o
);

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            case (wr_addr)
                ADR_CTRL: begin
                    cfg_d.en   = wr_data[0];
                    cfg_d.psel = wr_data[2:1];
                end
                ADR_SLEEP_HI:  cfg_d.sleep_cnt[15:8]  = wr_data;
                ADR_SLEEP_LO:  cfg_d.sleep_cnt[7:0]   = wr_data;
                ADR_HOST:      cfg_d.host_cnt         = wr_data;
                ADR_SETTLE_HI: cfg_d.settle_cnt[15:8] = wr_data;
                ADR_SETTLE_LO: cfg_d.settle_cnt[7:0]  = wr_data;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg_o = cfg_q;

    // R2
    host_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADR_HOST) |=> (cfg_q.host_cnt == $past(wr_data)));

endmodule

// File: rtl/wake_seq_tick.sv
module wake_seq_tick #(
    parameter int TICK_CYCLES = 12,
    parameter int PRE_SHIFT   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       restart,
    input  logic [1:0] psel,
    output logic       base_tick,
    output logic       slow_tick
);

    localparam int DW = (TICK_CYCLES > 2) ? $clog2(TICK_CYCLES) : 1;
    localparam int PW = PRE_SHIFT * 3;
    localparam logic [DW-1:0] DIV_MAX = DW'(TICK_CYCLES - 1);

    typedef struct packed {
        logic [DW-1:0] div;
        logic [PW-1:0] pre;
    } tick_t;

    tick_t t_d, t_q;
    logic [PW:0]   one_sh;
    logic [PW-1:0] pre_lim;

    always_comb begin
        one_sh    = (PW+1)'(1) << (PRE_SHIFT * int'(psel));
        pre_lim   = PW'(one_sh - 1'b1);
        base_tick = run && (t_q.div == DIV_MAX);
        slow_tick = base_tick && (t_q.pre == pre_lim);
        t_d       = t_q;
        if (!run || restart) begin
            t_d = '0;
        end else if (base_tick) begin
            t_d.div = '0;
            t_d.pre = slow_tick ? '0 : t_q.pre + 1'b1;
        end else begin
            t_d.div = t_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    // R4
    slow_on_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slow_tick |-> base_tick);

endmodule

// File: rtl/wake_seq_fsm.sv
module wake_seq_fsm
    import wake_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  cfg_t cfg,
    input  logic base_tick,
    input  logic slow_tick,
    output logic run,
    output logic restart,
    output logic wake_n,
    output logic pwr_down,
    output logic rx_en
);

    typedef struct packed {
        phase_e      ph;
        logic [15:0] cnt;
        logic        rx;
    } seq_t;

    seq_t s_d, s_q;
    logic tick_sel;

    always_comb begin
        s_d      = s_q;
        s_d.rx   = 1'b0;
        restart  = 1'b0;
        tick_sel = (s_q.ph == PH_SLEEP) ? slow_tick : base_tick;
        if (!cfg.en) begin
            s_d.ph  = PH_IDLE;
            s_d.cnt = '0;
        end else if (s_q.ph == PH_IDLE) begin
            s_d.ph  = PH_SLEEP;
            s_d.cnt = cfg.sleep_cnt;
            restart = 1'b1;
        end else if (tick_sel) begin
            if (s_q.cnt == '0) begin
                restart = 1'b1;
                case (s_q.ph)
                    PH_SLEEP: begin
                        s_d.ph  = PH_HOST;
                        s_d.cnt = {8'h00, cfg.host_cnt};
                    end
                    PH_HOST: begin
                        s_d.ph  = PH_SETTLE;
                        s_d.cnt = cfg.settle_cnt;
                    end
                    default: begin
                        s_d.ph  = PH_SLEEP;
                        s_d.cnt = cfg.sleep_cnt;
                        s_d.rx  = 1'b1;
                    end
                endcase
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{ph: PH_IDLE, cnt: '0, rx: 1'b0};
        else        s_q <= s_d;
    end

    assign run      = (s_q.ph != PH_IDLE);
    assign pwr_down = (s_q.ph == PH_SLEEP);
    assign wake_n   = !((s_q.ph == PH_HOST) || (s_q.ph == PH_SETTLE));
    assign rx_en    = s_q.rx;

    // R10
    excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pwr_down && !wake_n));

    // R7
    rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_en |=> !rx_en);

    // R7
    rx_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_en |-> (pwr_down && wake_n));

    // R8
    idle_on_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.en |=> (!run && wake_n && !pwr_down && !rx_en));

    // R5
    wake_from_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wake_n) |-> $past(pwr_down));

endmodule

// File: rtl/wake_seq_top.sv
module wake_seq_top
    import wake_seq_pkg::*;
#(
    parameter int TICK_CYCLES = 12,
    parameter int PRE_SHIFT   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [3:0] wr_addr,
    input  logic [7:0] wr_data,
    output logic       wake_n,
    output logic       pwr_down,
    output logic       rx_en
);

    cfg_t cfg;
    logic base_tick, slow_tick, run, restart;

    wake_seq_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cfg_o   (cfg)
    );

    wake_seq_tick #(
        .TICK_CYCLES (TICK_CYCLES),
        .PRE_SHIFT   (PRE_SHIFT)
    ) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .restart   (restart),
        .psel      (cfg.psel),
        .base_tick (base_tick),
        .slow_tick (slow_tick)
    );

    wake_seq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg       (cfg),
        .base_tick (base_tick),
        .slow_tick (slow_tick),
        .run       (run),
        .restart   (restart),
        .wake_n    (wake_n),
        .pwr_down  (pwr_down),
        .rx_en     (rx_en)
    );

endmodule

// File: tb/sim_wake_seq_top.sv
module sim_wake_seq_top;

    localparam int CLK_PERIOD = 10;
    localparam int TICKS      = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       wake_n, pwr_down, rx_en;

    int vectors = 0;
    int miscompares = 0;
    bit checking = 1'b0;
    bit done = 1'b0;

    // behavioural reference state
    int m_ph = 0;   // 0 idle, 1 sleep, 2 host, 3 settle
    int m_el = 0;
    int m_len = 0;
    bit m_rx = 1'b0;
    bit m_en = 1'b0;
    int m_sel = 0;
    int m_sleep = 0;
    int m_host = 0;
    int m_settle = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wake_seq_top #(.TICK_CYCLES(TICKS)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wake_n(wake_n), .pwr_down(pwr_down), .rx_en(rx_en)
    );

    function automatic int sleep_len();
        return (m_sleep + 1) * (1 << (2 * m_sel)) * TICKS;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ph = 0; m_el = 0; m_len = 0; m_rx = 0;
            m_en = 0; m_sel = 0; m_sleep = 0; m_host = 0; m_settle = 0;
        end else begin
            m_rx = 0;
            if (!m_en) begin
                m_ph = 0;
            end else if (m_ph == 0) begin
                m_ph = 1; m_el = 0; m_len = sleep_len();
            end else begin
                m_el++;
                if (m_el == m_len) begin
                    m_el = 0;
                    case (m_ph)
                        1: begin m_ph = 2; m_len = (m_host + 1) * TICKS; end
                        2: begin m_ph = 3; m_len = (m_settle + 1) * TICKS; end
                        default: begin m_ph = 1; m_len = sleep_len(); m_rx = 1; end
                    endcase
                end
            end
            if (wr_en) begin
                case (wr_addr)
                    4'h1: begin m_en = wr_data[0]; m_sel = int'(wr_data[2:1]); end
                    4'h4: m_sleep = (int'(wr_data) << 8) | (m_sleep & 255);
                    4'h5: m_sleep = (m_sleep & 65280) | int'(wr_data);
                    4'h6: m_host = int'(wr_data);
                    4'h7: m_settle = (int'(wr_data) << 8) | (m_settle & 255);
                    4'h8: m_settle = (m_settle & 65280) | int'(wr_data);
                    default: ;
                endcase
            end
        end
    end

    task automatic cmp(input string req, input string name, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s at %0t: actual %b expected %b", req, name, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (checking && !done) begin
            cmp("R3", "pwr_down", pwr_down, m_ph == 1);
            cmp("R5", "wake_n", wake_n, !(m_ph == 2 || m_ph == 3));
            cmp("R7", "rx_en", rx_en, m_rx);
        end
    end

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        if (!done) begin
            done = 1'b1;
            miscompares++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        idle(2);
        // R1: reset state, sampled with reset still held
        cmp("R1", "wake_n reset", wake_n, 1'b1);
        cmp("R1", "pwr_down reset", pwr_down, 1'b0);
        cmp("R1", "rx_en reset", rx_en, 1'b0);
        rst_n = 1'b1;
        checking = 1'b1;
        idle(3);

        // R1, R9: zero registers, each phase lasts one tick
        wr(4'h1, 8'h01);
        idle(40);
        // R8: clear the mode, then stay idle
        wr(4'h1, 8'h00);
        idle(10);

        // R2: stray addresses must not alias into the timers
        wr(4'hE, 8'hFF); wr(4'h0, 8'hFF); wr(4'h3, 8'hFF); wr(4'h9, 8'hFF);
        wr(4'hC, 8'hFF); wr(4'hD, 8'hFF); wr(4'hF, 8'hFF); wr(4'h2, 8'hFF);
        // R3, R5, R6, R7: plain counts, prescale 1
        wr(4'h5, 8'd2); wr(4'h6, 8'd3); wr(4'h8, 8'd1);
        wr(4'h1, 8'h01);
        idle(150);
        wr(4'h1, 8'h00);
        idle(5);

        // R2: upper bytes of both 16-bit counts
        wr(4'h4, 8'h01); wr(4'h5, 8'h00); wr(4'h7, 8'h01); wr(4'h8, 8'h00);
        wr(4'h6, 8'd0);
        wr(4'h1, 8'h01);
        idle(2400);
        wr(4'h1, 8'h00);
        wr(4'h4, 8'h00); wr(4'h5, 8'h01); wr(4'h7, 8'h00); wr(4'h8, 8'h02);
        wr(4'h6, 8'd1);

        // R4: each prescale ratio
        for (int s = 0; s < 4; s++) begin
            wr(4'h1, 8'((s << 1) | 1));
            idle(2 * (1 << (2 * s)) * TICKS + 40);
            wr(4'h1, 8'h00);
            idle(4);
        end

        // R8: clear during the host-recovery phase
        wr(4'h5, 8'd0); wr(4'h6, 8'd20);
        wr(4'h1, 8'h01);
        idle(TICKS + 10);
        wr(4'h1, 8'h00);
        idle(20);
        // R8: clear during settle
        wr(4'h6, 8'd0); wr(4'h8, 8'd30);
        wr(4'h1, 8'h01);
        idle(3 * TICKS + 8);
        wr(4'h1, 8'h00);
        idle(20);
        // R10: long mixed run
        wr(4'h8, 8'd2); wr(4'h6, 8'd4); wr(4'h5, 8'd5);
        wr(4'h1, 8'h03);
        idle(600);
        wr(4'h1, 8'h00);
        idle(5);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule